// File: doc/BRIEF.md
# Prefetchable Single-Entry Random Word Cache

This block sits between a small processor core and an entropy source and holds at most one 256-bit random word. The core reaches it through register accesses. Index 0xFC0 selects the random register, and a read of it takes the held word and leaves the holder empty. Index 0xFC1 selects a prefetch register. Any write to it asks the entropy source for a word in advance, so that a later random read can be served without waiting.

When a consuming read finds the holder empty, the block raises a stall toward the core and holds it until a word arrives. It asks the entropy source for a word unless a request is already in flight. A word that arrives in the same cycle as a stalled read goes straight to the reader and is not kept. The entropy side is a plain req/ack handshake. A word is transferred in the cycle where both are high.

Top module: `rand_word_cache`

## Requirements
- R1: After reset the holder is empty, `ent_req_o` is low, and the first consuming read stalls.
- R2: A swap (op 00) or set-bits (op 01) access to index 0xFC1 starts an entropy request when the holder is empty and no request is outstanding. It never stalls, and it returns zero on `csr_rdata_o`.
- R3: `ent_req_o` rises in the cycle after a request is started. It stays high until the cycle in which `ent_ack_i` is seen, and it is low in the following cycle.
- R4: The word on `ent_data_i` is taken in the cycle where `ent_req_o` and `ent_ack_i` are both high. Every word delivered is handed to exactly one consuming read, in delivery order.
- R5: A consuming read of a full holder completes in the same cycle without a stall, returns the held word on `rnd_data_o`, and leaves the holder empty.
- R6: A consuming read of an empty holder stalls until a word is delivered. It starts a request only if none is outstanding. With no request outstanding and an entropy latency of D cycles, it stalls for D+1 cycles.
- R7: When a word is delivered in the same cycle as a consuming read of an empty holder, the word passes straight to the reader, the stall drops, and the holder stays empty.
- R8: A prefetch access while a request is outstanding, or while the holder is full, has no effect.
- R9: At index 0xFC0, a swap (op 00) with a nonzero destination, a set-bits (op 01) access and a wide read (op 10) all consume. A swap whose destination is register zero neither consumes, requests nor stalls. Op 11 does nothing.
- R10: When a read consumes, `csr_rdata_o` carries bits 31:0 of the word it takes. Otherwise `csr_rdata_o` and `rnd_data_o` are zero. Accesses to any other index have no effect.
- R11: At most one request is outstanding at a time, and no request is outstanding while the holder is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| acc_valid_i | input | 1 | Core presents a register access; held while stalled |
| acc_addr_i | input | 12 | Register index of the access |
| acc_op_i | input | 2 | 00 swap, 01 set-bits, 10 wide read, 11 none |
| acc_dest_zero_i | input | 1 | Destination of the access is register zero |
| acc_stall_o | output | 1 | Hold the access; random word not yet available |
| csr_rdata_o | output | 32 | Low bits of the consumed word, else zero |
| rnd_data_o | output | 256 | Full consumed word, else zero |
| ent_req_o | output | 1 | Request to the entropy source |
| ent_ack_i | input | 1 | Entropy source acknowledges; data valid with req |
| ent_data_i | input | 256 | Entropy word |

## Verification
The embedded assertions check several properties on every cycle. They check the shape of the request: it is held until acknowledged and dropped afterwards, and it never coexists with a full holder. They check that a delivered word is captured unless it is read in the same cycle, that a consuming read empties the holder, and that a stall always has a request behind it on the next cycle. They also check that prefetches are ignored while the holder is full and that the same-cycle pass-through presents the incoming word. Only the bench scenarios can show the end-to-end ordering of delivered words to readers. The same holds for the exact stall length against entropy latency, and for the absence of extra requests after repeated prefetches. It also holds for the read-as-zero prefetch register, the destination-zero decode and the fact that one prefetch covers only one read.

// File: rtl/rndc_pkg.sv
// Shared definitions for the random word cache.
// Assumes: access operations are encoded on two bits by the core.
package rndc_pkg;
    typedef enum logic [1:0] {
        ACC_SWAP = 2'b00,
        ACC_SET  = 2'b01,
        ACC_WIDE = 2'b10,
        ACC_NONE = 2'b11
    } acc_op_e;
endpackage

// File: rtl/rndc_decode.sv
// Access decoder: classifies a core register access as a consuming random
// read, a prefetch write, or neither.
// Assumes: RndIdx and PfIdx differ; acc_op_i follows rndc_pkg::acc_op_e.
module rndc_decode #(
    parameter int              AddrW  = 12,
    parameter logic [AddrW-1:0] RndIdx = 12'hFC0,
    parameter logic [AddrW-1:0] PfIdx  = 12'hFC1
) (
    input  logic             valid_i,
    input  logic [AddrW-1:0] addr_i,
    input  logic [1:0]       op_i,
    input  logic             dest_zero_i,
    output logic             take_o,
    output logic             pf_o
);
    import rndc_pkg::*;

    logic    hit_rnd;
    logic    hit_pf;
    logic    is_write;
    acc_op_e op;

    assign op      = acc_op_e'(op_i);
    assign hit_rnd = valid_i && (addr_i == RndIdx);
    assign hit_pf  = valid_i && (addr_i == PfIdx);

    // Decide whether the access consumes a word and whether it writes.
    always_comb begin
        take_o   = 1'b0;
        is_write = 1'b0;
        unique case (op)
            ACC_SWAP: begin
                take_o   = hit_rnd && !dest_zero_i;
                is_write = 1'b1;
            end
            ACC_SET: begin
                take_o   = hit_rnd;
                is_write = 1'b1;
            end
            ACC_WIDE: begin
                take_o   = hit_rnd;
                is_write = 1'b0;
            end
            default: begin
                take_o   = 1'b0;
                is_write = 1'b0;
            end
        endcase
    end

    assign pf_o = hit_pf && is_write;
endmodule

// File: rtl/rndc_fetch.sv
// Request tracker: keeps one entropy request outstanding from start until
// acknowledge.
// Assumes: start_i is only raised while no request is outstanding.
module rndc_fetch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic ack_i,
    output logic req_o,
    output logic fire_o
);
    logic pend_q;

    // Track the outstanding request: set on start, cleared on acknowledge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
        end else if (pend_q && ack_i) begin
            pend_q <= 1'b0;
        end else if (start_i) begin
            pend_q <= 1'b1;
        end
    end

    assign req_o  = pend_q;
    assign fire_o = pend_q && ack_i;

    a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !ack_i) |=> req_o);
    a_r3_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && ack_i) |=> !req_o);
    a_r11_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !req_o);
endmodule

// File: rtl/rndc_store.sv
// Word holder: one entry of WordW bits with a full flag; presents the held
// word, or the incoming word when the holder is empty and a fill arrives.
// Assumes: take_i is only raised when avail_o is high.
module rndc_store #(
    parameter int WordW = 256
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fill_i,
    input  logic [WordW-1:0] data_i,
    input  logic             take_i,
    output logic             full_o,
    output logic             avail_o,
    output logic [WordW-1:0] word_o
);
    logic             full_q;
    logic [WordW-1:0] data_q;

    // Update occupancy and contents: a take empties, a fill without a take loads.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take_i) begin
            full_q <= 1'b0;
        end else if (fill_i) begin
            full_q <= 1'b1;
            data_q <= data_i;
        end
    end

    assign full_o  = full_q;
    assign avail_o = full_q || fill_i;
    assign word_o  = full_q ? data_q : data_i;

    a_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_i && !take_i) |=> (full_q && data_q == $past(data_i)));
    a_r5_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> !full_q);
endmodule

// File: rtl/rand_word_cache.sv
// Single-entry random word cache: serves consuming reads of the random
// register, stalls the core while empty, and fetches from an entropy source
// on demand or on a prefetch write.
// Assumes: the core holds its access stable while acc_stall_o is high; the
// entropy source keeps ent_data_i valid in the cycle it raises ent_ack_i.
module rand_word_cache #(
    parameter int               WordW  = 256,
    parameter int               CsrW   = 32,
    parameter int               AddrW  = 12,
    parameter logic [AddrW-1:0] RndIdx = 12'hFC0,
    parameter logic [AddrW-1:0] PfIdx  = 12'hFC1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acc_valid_i,
    input  logic [AddrW-1:0] acc_addr_i,
    input  logic [1:0]       acc_op_i,
    input  logic             acc_dest_zero_i,
    output logic             acc_stall_o,
    output logic [CsrW-1:0]  csr_rdata_o,
    output logic [WordW-1:0] rnd_data_o,
    output logic             ent_req_o,
    input  logic             ent_ack_i,
    input  logic [WordW-1:0] ent_data_i
);
    logic             take_req;
    logic             pf;
    logic             take;
    logic             start;
    logic             fire;
    logic             full;
    logic             avail;
    logic [WordW-1:0] word;

    rndc_decode #(
        .AddrW  (AddrW),
        .RndIdx (RndIdx),
        .PfIdx  (PfIdx)
    ) u_decode (
        .valid_i     (acc_valid_i),
        .addr_i      (acc_addr_i),
        .op_i        (acc_op_i),
        .dest_zero_i (acc_dest_zero_i),
        .take_o      (take_req),
        .pf_o        (pf)
    );

    rndc_fetch u_fetch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .ack_i   (ent_ack_i),
        .req_o   (ent_req_o),
        .fire_o  (fire)
    );

    rndc_store #(
        .WordW (WordW)
    ) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fill_i  (fire),
        .data_i  (ent_data_i),
        .take_i  (take),
        .full_o  (full),
        .avail_o (avail),
        .word_o  (word)
    );

    // Join decode and occupancy: stall, consume, and request start.
    always_comb begin
        take        = take_req && avail;
        acc_stall_o = take_req && !avail;
        start       = !ent_req_o && !full && (pf || take_req);
    end

    // Drive read data only for a completing consuming read.
    always_comb begin
        rnd_data_o  = take ? word : '0;
        csr_rdata_o = take ? word[CsrW-1:0] : '0;
    end

    a_r11_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(full && ent_req_o));
    a_r6_stall_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_stall_o |=> ent_req_o);
    a_r7_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_req && !full && ent_req_o && ent_ack_i)
            |-> (!acc_stall_o && rnd_data_o == ent_data_i));
    a_r2_pf_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pf && !full && !ent_req_o) |=> ent_req_o);
    a_r8_pf_full_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pf && full) |=> !ent_req_o);
    a_r9_dz_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_valid_i && acc_op_i == 2'b00 && acc_dest_zero_i && !ent_req_o)
            |=> (full == $past(full)));
endmodule

// File: tb/test_rand_word_cache.sv
// Scoreboard bench: the entropy driver pushes each delivered word into a
// queue; the monitor pops one per completing consuming read and compares.
module test_rand_word_cache;
    localparam int W = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [11:0]   acc_addr = '0;
    logic [1:0]    acc_op = 2'b11;
    logic          acc_dz = 1'b0;
    logic          acc_stall;
    logic [31:0]   csr_rdata;
    logic [W-1:0]  rnd_data;
    logic          ent_req;
    logic          ent_ack = 1'b0;
    logic [W-1:0]  ent_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int n_req = 0;
    int n_req_hi = 0;
    int ent_delay = 3;
    int widx = 1;
    bit prev_req = 1'b0;
    logic [W-1:0] exp_q[$];

    always #2 clk = ~clk;

    rand_word_cache i_rand_word_cache (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .acc_valid_i     (acc_valid),
        .acc_addr_i      (acc_addr),
        .acc_op_i        (acc_op),
        .acc_dest_zero_i (acc_dz),
        .acc_stall_o     (acc_stall),
        .csr_rdata_o     (csr_rdata),
        .rnd_data_o      (rnd_data),
        .ent_req_o       (ent_req),
        .ent_ack_i       (ent_ack),
        .ent_data_i      (ent_data)
    );

    function automatic logic [W-1:0] mk_word(int idx);
        logic [W-1:0] w;
        for (int l = 0; l < 8; l++) w[l*32 +: 32] = 32'h5A000000 + idx * 32'h00010101 + l;
        return w;
    endfunction

    function automatic bit b_take(logic [11:0] a, logic [1:0] op, logic dz);
        if (a != 12'hFC0) return 1'b0;
        return (op == 2'b00 && !dz) || op == 2'b01 || op == 2'b10;
    endfunction

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Entropy source model: ack after ent_delay cycles of req, one word per request.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (rst_n && ent_req) begin
                if (cnt >= ent_delay && !ent_ack) begin
                    ent_ack  = 1'b1;
                    ent_data = mk_word(widx);
                    widx++;
                end else begin
                    ent_ack = 1'b0;
                end
                cnt++;
            end else begin
                ent_ack = 1'b0;
                cnt = 0;
            end
        end
    end

    // Monitor: record deliveries and requests, score completing reads.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (ent_req && ent_ack) exp_q.push_back(ent_data);
                if (ent_req && !prev_req) n_req++;
                if (ent_req) n_req_hi++;
                prev_req = ent_req;
                if (acc_valid && b_take(acc_addr, acc_op, acc_dz) && !acc_stall) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4 read completed with no delivered word", rnd_data, '0);
                    end else begin
                        logic [W-1:0] e;
                        e = exp_q.pop_front();
                        chk(rnd_data == e, "R5 scoreboard word", rnd_data, e);
                        chk(csr_rdata == e[31:0], "R10 csr low bits", W'(csr_rdata), W'(e[31:0]));
                    end
                end else begin
                    chk(rnd_data == '0 && csr_rdata == '0, "R10 idle read data zero",
                        rnd_data | W'(csr_rdata), '0);
                end
            end
        end
    end

    task automatic access(input logic [1:0] op, input logic [11:0] a, input bit dz,
                          output int stalls, output logic [31:0] csr_out);
        @(negedge clk);
        acc_valid = 1'b1; acc_op = op; acc_addr = a; acc_dz = dz;
        #1;
        stalls = 0;
        while (acc_stall) begin
            @(negedge clk);
            #1;
            stalls++;
        end
        csr_out = csr_rdata;
        @(negedge clk);
        acc_valid = 1'b0; acc_op = 2'b11;
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk);
            #1;
        end while (ent_req);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s;
        int r0;
        int h0;
        logic [31:0] c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!ent_req && !acc_stall, "R1 reset req/stall low", W'({ent_req, acc_stall}), '0);

        // R1/R6: first read of empty holder stalls D+1 cycles, one request.
        ent_delay = 3; r0 = n_req;
        access(2'b00, 12'hFC0, 1'b0, s, c);
        chk(s == 4, "R6 R1 empty read stall length", W'(s), W'(4));
        chk(n_req - r0 == 1, "R6 one request", W'(n_req - r0), W'(1));

        // R2/R3: prefetch, req held D+1 cycles, reads as zero.
        ent_delay = 4; r0 = n_req; h0 = n_req_hi;
        access(2'b00, 12'hFC1, 1'b0, s, c);
        chk(s == 0 && c == 32'd0, "R2 prefetch no stall, reads zero", W'({s, c}), '0);
        wait_idle();
        chk(n_req_hi - h0 == 5, "R3 req high cycles", W'(n_req_hi - h0), W'(5));
        chk(n_req - r0 == 1, "R2 prefetch issued one request", W'(n_req - r0), W'(1));

        // R8: prefetch while full ignored; R5 full read no stall.
        r0 = n_req;
        access(2'b01, 12'hFC1, 1'b0, s, c);
        repeat (4) @(negedge clk);
        chk(n_req == r0, "R8 prefetch while full ignored", W'(n_req - r0), '0);
        access(2'b00, 12'hFC0, 1'b0, s, c);
        chk(s == 0, "R5 full read no stall", W'(s), '0);
        access(2'b00, 12'hFC0, 1'b0, s, c);
        chk(s == 5, "R5 holder emptied by read", W'(s), W'(5));

        // R8: second prefetch while outstanding ignored; R6 read joins it.
        ent_delay = 8; r0 = n_req;
        access(2'b00, 12'hFC1, 1'b0, s, c);
        access(2'b01, 12'hFC1, 1'b0, s, c);
        access(2'b10, 12'hFC0, 1'b0, s, c);
        chk(s > 0, "R6 read behind outstanding request stalls", W'(s), W'(1));
        chk(n_req - r0 == 1, "R8 R6 no extra request", W'(n_req - r0), W'(1));

        // R9: destination-zero swap when empty: no stall, no request.
        r0 = n_req;
        access(2'b00, 12'hFC0, 1'b1, s, c);
        repeat (4) @(negedge clk);
        chk(s == 0 && n_req == r0, "R9 dest-zero on empty", W'({s, n_req - r0}), '0);

        // R10: other index and op 11 have no effect.
        access(2'b00, 12'h7C0, 1'b0, s, c);
        access(2'b11, 12'hFC0, 1'b0, s, c);
        repeat (4) @(negedge clk);
        chk(s == 0 && n_req == r0, "R10 R9 other index / op none", W'({s, n_req - r0}), '0);

        // R9: destination-zero swap on full keeps the word.
        ent_delay = 2;
        access(2'b00, 12'hFC1, 1'b0, s, c);
        wait_idle();
        access(2'b00, 12'hFC0, 1'b1, s, c);
        access(2'b01, 12'hFC0, 1'b1, s, c);
        chk(s == 0, "R9 set-bits consumes kept word without stall", W'(s), '0);

        // R7: zero-latency delivery passes through; holder stays empty.
        ent_delay = 0;
        access(2'b10, 12'hFC0, 1'b0, s, c);
        chk(s == 1, "R7 pass-through stall length", W'(s), W'(1));
        ent_delay = 2;
        access(2'b00, 12'hFC0, 1'b0, s, c);
        chk(s == 3, "R7 holder empty after pass-through", W'(s), W'(3));

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4 every delivered word consumed", W'(exp_q.size()), '0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule